// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources of a parallel-port and timer peripheral into one pending-flag register, masks those flags with an enable register, and drives a single active-high interrupt request toward the processor. The port and timer logic around it deliver one-cycle set pulses when an event occurs and one-cycle clear pulses when their own side effects retire an event. The processor reaches the block through a plain register strobe interface that decodes a 4-bit offset.

Software sees two registers. In the flag register, bit 7 is a live summary bit. The enable register is updated by a set-or-clear write, in which bit 7 of the written byte selects the operation. An access to the shift-register offset (read or write) retires the shift-register flag. There is no streamed data here, so every pin is a plain control or status pin and no valid/ready handshake applies. A register access completes in the cycle it is strobed and can never be stalled.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, a read at offset 0xD returns 0x00, a read at offset 0xE returns 0x80, and `irq` is low.
- R2: The source bits are fixed as follows: bit 0 CA2, bit 1 CA1, bit 2 shift register, bit 3 CB2, bit 4 CB1, bit 5 timer 2, bit 6 timer 1. A 1 on `src_set[k]` at a clock edge makes flag bit k read as 1 from that edge on.
- R3: A write at offset 0xE whose bit 7 is 1 sets every enable bit that is 1 in data bits 6..0 and leaves the other enable bits unchanged.
- R4: A write at offset 0xE whose bit 7 is 0 clears every enable bit that is 1 in data bits 6..0 and leaves the other enable bits unchanged.
- R5: Bit 7 of a read at offset 0xE is always 1.
- R6: Bit 7 of a read at offset 0xD is 1 exactly when (flags & enables & 0x7F) is nonzero. This bit follows the current register contents with no added delay.
- R7: In a write at offset 0xD, each 1 in data bits 6..0 clears the matching flag and each 0 leaves it unchanged. No processor write sets a flag.
- R8: A 1 on `src_clr[k]` at a clock edge clears flag bit k.
- R9: A read strobe or a write strobe at offset 0xA clears flag bit 2 and leaves every other flag unchanged.
- R10: If a set pulse and any clear request for the same bit arrive at the same edge, the flag is set.
- R11: `irq` is registered. It rises one cycle after an enabled flag becomes set. It stays high for as long as an enabled flag remains set, and it falls one cycle after the last enabled flag is cleared or has its enable removed.
- R12: A flag whose enable bit is 0 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 7 | Per-source set pulses from port and timer logic |
| src_clr | input | 7 | Per-source clear pulses from port and timer logic |
| reg_ofs | input | 4 | Register offset of the processor access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe (used only for read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_ofs`; combinational from the registers |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
Flag and enable updates take effect at the clock edge that samples the pulse or strobe. The read data path is combinational, so the bench drives each stimulus on a falling edge, removes it on the next falling edge, and reads both registers just after that second falling edge. `irq` lags the flag and enable registers by one more register stage. For that reason the bench samples it one full cycle after the register reads. A directed test also confirms that `irq` is still low at the first sample point and is high only at the second.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_NSRC = 7;
  localparam int unsigned IRQC_DW   = 8;
  localparam int unsigned IRQC_AW   = 4;

  localparam int unsigned SRC_CA2 = 0;
  localparam int unsigned SRC_CA1 = 1;
  localparam int unsigned SRC_SHF = 2;
  localparam int unsigned SRC_CB2 = 3;
  localparam int unsigned SRC_CB1 = 4;
  localparam int unsigned SRC_TM2 = 5;
  localparam int unsigned SRC_TM1 = 6;

  localparam logic [IRQC_AW-1:0] OFS_SHIFT = 4'hA;
  localparam logic [IRQC_AW-1:0] OFS_FLAG  = 4'hD;
  localparam logic [IRQC_AW-1:0] OFS_MASK  = 4'hE;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE
  } acc_kind_e;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[k] <= 1'b0;
      else if (set_i[k])  flag_q[k] <= 1'b1;
      else if (clr_i[k])  flag_q[k] <= 1'b0;
    end
  end

  assign flags_o = flag_q;

  // R10: a set pulse always lands, whatever clears arrive with it
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R7: no flag rises without a set pulse
  p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));

  // R8: a clear without a set drops the flag
  p_clear_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         set_mode_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_i) begin
      if (set_mode_i) en_q <= en_q | sel_i;
      else            en_q <= en_q & ~sel_i;
    end
  end

  assign en_o = en_q;

  // R3: set-mode write raises selected bits, keeps the rest
  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_mode_i) |=>
      (((en_q & $past(sel_i)) == $past(sel_i)) &&
       ((en_q & ~$past(sel_i)) == ($past(en_q) & ~$past(sel_i)))));

  // R4: clear-mode write drops selected bits, keeps the rest
  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !set_mode_i) |=>
      (((en_q & $past(sel_i)) == '0) &&
       ((en_q & ~$past(sel_i)) == ($past(en_q) & ~$past(sel_i)))));
endmodule

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         pending_o,
  output logic         irq_o
);
  logic irq_q;

  assign pending_o = |(flags_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_o;
  end

  assign irq_o = irq_q;

  // R12: nothing enabled and set means no request next cycle
  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_i) == '0) |=> !irq_o);

  // R11: an enabled, set flag raises the request one cycle later
  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & en_i) != '0) |=> irq_o);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = IRQC_NSRC,
  parameter int unsigned DW   = IRQC_DW,
  parameter int unsigned AW   = IRQC_AW,
  parameter int unsigned SHF_BIT = SRC_SHF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic [AW-1:0]   reg_ofs,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  localparam int unsigned MSB = DW - 1;

  if (NSRC != DW - 1) begin : g_bad_width
    initial $display("irq_flag_ctrl: NSRC must equal DW-1");
  end

  acc_kind_e    acc;
  logic         hit_flag, hit_mask, hit_shift;
  logic [NSRC-1:0] cpu_clr, shf_clr, all_clr;
  logic [NSRC-1:0] flags, enables;
  logic         pending;

  always_comb begin
    if (reg_wr)      acc = ACC_WRITE;
    else if (reg_rd) acc = ACC_READ;
    else             acc = ACC_NONE;
  end

  assign hit_flag  = (reg_ofs == OFS_FLAG);
  assign hit_mask  = (reg_ofs == OFS_MASK);
  assign hit_shift = (reg_ofs == OFS_SHIFT);

  assign cpu_clr = (acc == ACC_WRITE && hit_flag) ? reg_wdata[NSRC-1:0] : '0;
  assign shf_clr = (acc != ACC_NONE && hit_shift) ? (NSRC'(1) << SHF_BIT) : '0;
  assign all_clr = src_clr | cpu_clr | shf_clr;

  irqc_flag_bank #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (src_set),
    .clr_i   (all_clr),
    .flags_o (flags)
  );

  irqc_enable_bank #(.N(NSRC)) u_enables (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (acc == ACC_WRITE && hit_mask),
    .set_mode_i (reg_wdata[MSB]),
    .sel_i      (reg_wdata[NSRC-1:0]),
    .en_o       (enables)
  );

  irqc_request #(.N(NSRC)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (flags),
    .en_i      (enables),
    .pending_o (pending),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_flag)      reg_rdata = {pending, flags};
    else if (hit_mask) reg_rdata = {1'b1, enables};
  end

  // R9: an access at the shift offset without a set retires bit 2 only
  p_shift_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && hit_shift && !src_set[SHF_BIT]) |=> !flags[SHF_BIT]);

  // R5: the enable register's top bit always reads as 1
  p_mask_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mask |-> reg_rdata[MSB]);

  // R1: request is low in the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_set = '0;
  logic [6:0] src_clr = '0;
  logic [3:0] reg_ofs = 4'h0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .reg_ofs(reg_ofs), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {rd, wr, ofs[4], data[8], set[7], clr[7], exp_flag[8], exp_mask[8], exp_irq}
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0,1'b0,4'h0,8'h00,7'h40,7'h00,8'h40,8'h80,1'b0},
    {1'b0,1'b1,4'hE,8'hC0,7'h00,7'h00,8'hC0,8'hC0,1'b1},
    {1'b0,1'b1,4'hD,8'h40,7'h00,7'h00,8'h00,8'hC0,1'b0},
    {1'b0,1'b0,4'h0,8'h00,7'h03,7'h00,8'h03,8'hC0,1'b0},
    {1'b0,1'b1,4'hE,8'h82,7'h00,7'h00,8'h83,8'hC2,1'b1},
    {1'b0,1'b1,4'hE,8'h40,7'h00,7'h00,8'h83,8'h82,1'b1},
    {1'b0,1'b1,4'hE,8'h02,7'h00,7'h00,8'h03,8'h80,1'b0},
    {1'b0,1'b1,4'hD,8'h00,7'h00,7'h00,8'h03,8'h80,1'b0},
    {1'b0,1'b1,4'hD,8'h7C,7'h00,7'h00,8'h03,8'h80,1'b0},
    {1'b0,1'b0,4'h0,8'h00,7'h00,7'h01,8'h02,8'h80,1'b0},
    {1'b0,1'b0,4'h0,8'h00,7'h24,7'h04,8'h26,8'h80,1'b0},
    {1'b0,1'b1,4'hA,8'h55,7'h00,7'h00,8'h22,8'h80,1'b0},
    {1'b0,1'b1,4'hE,8'hFF,7'h00,7'h00,8'hA2,8'hFF,1'b1},
    {1'b0,1'b1,4'hD,8'h04,7'h04,7'h00,8'hA6,8'hFF,1'b1},
    {1'b1,1'b0,4'hA,8'h00,7'h00,7'h00,8'hA2,8'hFF,1'b1},
    {1'b0,1'b1,4'hD,8'h7F,7'h00,7'h00,8'h00,8'hFF,1'b0},
    {1'b0,1'b0,4'h0,8'h00,7'h18,7'h00,8'h98,8'hFF,1'b1},
    {1'b0,1'b1,4'hE,8'h7F,7'h00,7'h00,8'h18,8'h80,1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    src_set = '0; src_clr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_regs(output logic [7:0] f, output logic [7:0] m);
    reg_ofs = 4'hD; #1 f = reg_rdata;
    reg_ofs = 4'hE; #1 m = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; idle();
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] f, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_regs(f, m);
    chk("R1 flag after reset", f, 8'h00);
    chk("R1 mask after reset", m, 8'h80);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      e = VEC[v];
      @(negedge clk);
      reg_rd = e[44]; reg_wr = e[43]; reg_ofs = e[42:39]; reg_wdata = e[38:31];
      src_set = e[30:24]; src_clr = e[23:17];
      @(negedge clk);
      idle();
      read_regs(f, m);
      chk($sformatf("vec %0d R2/R6/R7/R8/R9/R10 flag", v), f, e[16:9]);
      chk($sformatf("vec %0d R3/R4/R5 mask", v), m, e[8:1]);
      @(negedge clk); #1;
      chk($sformatf("vec %0d R11/R12 irq", v), {7'b0, irq}, {7'b0, e[0]});
    end

    // R11: one-cycle lag, then held until the enable is removed
    do_reset();
    @(negedge clk); reg_wr = 1'b1; reg_ofs = 4'hE; reg_wdata = 8'hA0;
    @(negedge clk); idle(); src_set = 7'h20;
    @(negedge clk); idle(); #1;
    chk("R11 irq not yet up at flag edge", {7'b0, irq}, 8'h00);
    reg_ofs = 4'hD; #1 chk("R2 timer2 flag bit 5", reg_rdata, 8'hA0);
    @(negedge clk); #1;
    chk("R11 irq up one cycle later", {7'b0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    #1 chk("R11 irq held", {7'b0, irq}, 8'h01);
    reg_wr = 1'b1; reg_ofs = 4'hE; reg_wdata = 8'h20;
    @(negedge clk); idle(); #1;
    chk("R11 irq still up at disable edge", {7'b0, irq}, 8'h01);
    reg_ofs = 4'hD; #1 chk("R12 summary drops, flag stays", reg_rdata, 8'h20);
    @(negedge clk); #1;
    chk("R12 irq low with flag masked", {7'b0, irq}, 8'h00);

    // R9: read of other offsets has no side effect; shift read keeps others
    @(negedge clk); src_set = 7'h7F;
    @(negedge clk); idle(); reg_rd = 1'b1; reg_ofs = 4'hD;
    @(negedge clk); idle(); reg_rd = 1'b1; reg_ofs = 4'hA;
    @(negedge clk); idle();
    reg_ofs = 4'hD; #1 chk("R9 shift read clears only bit 2", reg_rdata, 8'h7B);

    // R1: reset mid-run returns to idle values
    do_reset();
    read_regs(f, m);
    chk("R1 flag after second reset", f, 8'h00);
    chk("R1 mask after second reset", m, 8'h80);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule